// File: doc/BRIEF.md
# Control-Bit Operand ALU

This block is a purely combinational arithmetic/logic unit with two data operands of equal width and six independent single-bit controls. No opcode is decoded. Each operand passes through its own two-step conditioning stage: it is optionally cleared to zero, and the result is then optionally inverted bit by bit. A select bit then combines the two conditioned operands, either by addition or by bitwise AND. A final bit optionally inverts that result.

Composing these six bits gives a family of useful functions without any decoder. Examples are the constants 0, 1 and -1, pass-through, complement and negation of either operand, increment, decrement, sum, both differences and AND. Two status flags accompany the result: one marks an all-zero result and one copies the result's sign bit.

Every internal value is carried at the full data width. If an intermediate value is narrowed, results silently go wrong.

Top module: `ctl_alu`

## Requirements
- R1: When `zero_x_i` is 1, operand X is replaced by all zeros before any inversion; when it is 0, X passes unchanged into the inversion step.
- R2: When `inv_x_i` is 1, the already zero-conditioned X is inverted bit by bit, so `zero_x_i`=1 with `inv_x_i`=1 yields all ones.
- R3: `zero_y_i` and `inv_y_i` condition operand Y exactly as R1 and R2 condition X, clearing first and inverting second.
- R4: When `add_sel_i` is 1, the core result is the sum of the two conditioned operands modulo 2^W, with the carry out of the top bit discarded.
- R5: When `add_sel_i` is 0, the core result is the bitwise AND of the two conditioned operands.
- R6: When `inv_out_i` is 1, `res_o` is the bitwise inverse of the core result; otherwise it equals the core result.
- R7: `zr_o` is 1 exactly when every bit of `res_o` is 0.
- R8: `ng_o` equals bit W-1 of `res_o`.
- R9: All intermediate values are W bits wide, so for example 10 + 10 gives 20 and not a truncated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | W | Operand X |
| y_i | input | W | Operand Y |
| zero_x_i | input | 1 | Clear X before inversion |
| inv_x_i | input | 1 | Invert the conditioned X |
| zero_y_i | input | 1 | Clear Y before inversion |
| inv_y_i | input | 1 | Invert the conditioned Y |
| add_sel_i | input | 1 | 1 selects sum, 0 selects AND |
| inv_out_i | input | 1 | Invert the core result |
| res_o | output | W | Result word |
| zr_o | output | 1 | Result is all zeros |
| ng_o | output | 1 | Most significant bit of the result |

## Verification
A 4-bit instance is swept through every operand pair under all 64 control combinations. This sweep tells apart any mistake in the order of clearing and inverting, in the sum/AND selection, and in the flags, including results at the wrap-around point. A 16-bit instance is driven with the twelve named control patterns (constants, negation, increment, decrement, both differences and others) on chosen operand pairs. With 10 + 10 it separates a full-width datapath from one whose intermediate values have been narrowed.

// File: rtl/ctl_alu_pkg.sv
package ctl_alu_pkg;
    typedef struct packed {
        logic zero;
        logic inv;
    } cond_ctl_t;
endpackage

// File: rtl/opnd_cond.sv
module opnd_cond
    import ctl_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] raw_i,
    input  cond_ctl_t    ctl_i,
    output logic [W-1:0] cond_o
);
    logic [W-1:0] zeroed_d;
    logic [W-1:0] cond_d;

    always_comb begin
        zeroed_d = ctl_i.zero ? '0 : raw_i;
        cond_d   = ctl_i.inv ? ~zeroed_d : zeroed_d;
        // clearing happens before inversion
        p_clear_only_r1: assert (!(ctl_i.zero && !ctl_i.inv) || cond_d == '0);
        p_clear_then_inv_r2: assert (!(ctl_i.zero && ctl_i.inv) || cond_d == '1);
        p_pass_r1: assert (ctl_i.zero || ctl_i.inv || cond_d == raw_i);
    end

    assign cond_o = cond_d;
endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         add_i,
    output logic [W-1:0] core_o
);
    logic [W-1:0] sum_d;
    logic [W-1:0] and_d;
    logic [W-1:0] core_d;

    always_comb begin
        sum_d  = a_i + b_i;
        and_d  = a_i & b_i;
        core_d = add_i ? sum_d : and_d;
        p_and_within_a_r5: assert (add_i || (core_d & ~a_i) == '0);
        p_add_identity_r4: assert (!(add_i && b_i == '0) || core_d == a_i);
    end

    assign core_o = core_d;
endmodule

// File: rtl/out_stage.sv
module out_stage #(
    parameter int W = 16
) (
    input  logic [W-1:0] core_i,
    input  logic         inv_i,
    output logic [W-1:0] res_o,
    output logic         zr_o,
    output logic         ng_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] res_d;
    logic         zr_d;
    logic         ng_d;

    always_comb begin
        res_d = inv_i ? ~core_i : core_i;
        zr_d  = ~|res_d;
        ng_d  = res_d[MSB];
        p_inv_all_bits_r6: assert (!inv_i || (res_d ^ core_i) == '1);
        p_flags_exclusive_r7: assert (!(zr_d && ng_d));
        p_sign_of_nonzero_r8: assert (!ng_d || res_d != '0);
    end

    assign res_o = res_d;
    assign zr_o  = zr_d;
    assign ng_o  = ng_d;
endmodule

// File: rtl/ctl_alu.sv
module ctl_alu
    import ctl_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         zero_x_i,
    input  logic         inv_x_i,
    input  logic         zero_y_i,
    input  logic         inv_y_i,
    input  logic         add_sel_i,
    input  logic         inv_out_i,
    output logic [W-1:0] res_o,
    output logic         zr_o,
    output logic         ng_o
);
    cond_ctl_t    x_ctl, y_ctl;
    logic [W-1:0] x_cond, y_cond, core;

    assign x_ctl = '{zero: zero_x_i, inv: inv_x_i};
    assign y_ctl = '{zero: zero_y_i, inv: inv_y_i};

    opnd_cond #(.W(W)) u_cond_x (.raw_i(x_i), .ctl_i(x_ctl), .cond_o(x_cond));
    opnd_cond #(.W(W)) u_cond_y (.raw_i(y_i), .ctl_i(y_ctl), .cond_o(y_cond));   // R3

    alu_core #(.W(W)) u_core (.a_i(x_cond), .b_i(y_cond), .add_i(add_sel_i), .core_o(core));

    out_stage #(.W(W)) u_out (
        .core_i(core), .inv_i(inv_out_i),
        .res_o(res_o), .zr_o(zr_o), .ng_o(ng_o)
    );
endmodule

// File: tb/ctl_alu_bench.sv
module ctl_alu_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [15:0] x16, y16, r16;
    logic [3:0]  x4, y4, r4;
    logic [5:0]  c16, c4;   // {zx, nx, zy, ny, f, no}
    logic        zr16, ng16, zr4, ng4;

    ctl_alu #(.W(16)) u_ctl_alu (
        .x_i(x16), .y_i(y16),
        .zero_x_i(c16[5]), .inv_x_i(c16[4]), .zero_y_i(c16[3]), .inv_y_i(c16[2]),
        .add_sel_i(c16[1]), .inv_out_i(c16[0]),
        .res_o(r16), .zr_o(zr16), .ng_o(ng16)
    );

    ctl_alu #(.W(4)) u_ctl_alu_w4 (
        .x_i(x4), .y_i(y4),
        .zero_x_i(c4[5]), .inv_x_i(c4[4]), .zero_y_i(c4[3]), .inv_y_i(c4[2]),
        .add_sel_i(c4[1]), .inv_out_i(c4[0]),
        .res_o(r4), .zr_o(zr4), .ng_o(ng4)
    );

    function automatic int model(int w, int x, int y, logic [5:0] c);
        int m = (1 << w) - 1;
        int a = c[5] ? 0 : x;
        int b = c[3] ? 0 : y;
        int r;
        if (c[4]) a = ~a & m;
        if (c[2]) b = ~b & m;
        r = c[1] ? ((a + b) & m) : (a & b);
        if (c[0]) r = ~r & m;
        return r;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run16(string req, logic [5:0] c, int x, int y, int exp);
        x16 = 16'(x); y16 = 16'(y); c16 = c;
        @(negedge clk);
        check(req, int'(r16), exp & 16'hFFFF);
        check("R7", int'(zr16), ((exp & 16'hFFFF) == 0) ? 1 : 0);
        check("R8", int'(ng16), (exp >> 15) & 1);
        @(posedge clk);
    endtask

    initial begin
        x16 = '0; y16 = '0; c16 = '0;
        x4 = '0; y4 = '0; c4 = '0;
        @(posedge clk);
        // zero inputs with AND: all-zero result
        @(negedge clk);
        check("R5", int'(r16), 0);
        check("R7", int'(zr16), 1);
        @(posedge clk);

        // named control patterns on a 16-bit instance
        run16("R9 sum 10+10", 6'b000010, 10, 10, 20);
        run16("R4 X+Y", 6'b000010, 1234, 77, 1234 + 77);
        run16("R4 wrap", 6'b000010, 16'hFFFF, 2, 1);
        run16("R5 X&Y", 6'b000000, 16'hF0F3, 16'h3C3F, 16'h3033);
        run16("R1 const 0", 6'b101010, 999, 555, 0);
        run16("R2 const 1", 6'b111111, 999, 555, 1);
        run16("R2 const -1", 6'b111010, 999, 555, -1);
        run16("R3 X", 6'b001100, 4321, 7, 4321);
        run16("R6 not X", 6'b001101, 4321, 7, ~4321);
        run16("R6 neg X", 6'b001111, 4321, 7, -4321);
        run16("R6 X+1", 6'b011111, 4321, 7, 4322);
        run16("R3 X-1", 6'b001110, 4321, 7, 4320);
        run16("R6 X-Y", 6'b010011, 300, 1000, 300 - 1000);
        run16("R6 Y-X", 6'b000111, 300, 1000, 700);
        run16("R9 X-1 at 0", 6'b001110, 0, 0, -1);

        // exhaustive sweep on a 4-bit instance
        for (int c = 0; c < 64; c++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    int e;
                    x4 = 4'(x); y4 = 4'(y); c4 = 6'(c);
                    e = model(4, x, y, 6'(c));
                    @(negedge clk);
                    check((c & 2) != 0 ? "R4" : "R5", int'(r4), e);
                    check("R7", int'(zr4), (e == 0) ? 1 : 0);
                    check("R8", int'(ng4), (e >> 3) & 1);
                    @(posedge clk);
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule